// File: doc/BRIEF.md
# Burst-of-Four Double-Rate Masked Write Port

This block is the write side of a synchronous memory that has separate read and write data paths. A write request is taken on a rising clock edge when the active-low write select is low. Starting one full cycle later, four data beats follow on alternating clock edges: rising, falling, rising, falling. Each beat has its own pair of active-low lane strobes, which pick the 9-bit halves of the 18-bit word that get stored.

The four beats go to four consecutive words of an internal array. The burst starts at the request address with its two low bits cleared. Each write request takes two rising edges, so requests can follow one another on every second rising edge with no gap on the data bus. A plain combinational read port exposes the array contents for checking.

Top module: `qburst_wr_port`

## Requirements
- R1: A write burst starts only when `wr_sel_n` is low at a rising edge that is not the edge directly after an accepted request; with `wr_sel_n` high, data and strobes on the bus change nothing in the array.
- R2: For a request accepted at rising edge t, beat 0 is sampled at rising edge t+1, beat 1 at the falling edge t+1.5, beat 2 at rising edge t+2 and beat 3 at the falling edge t+2.5.
- R3: Lane 0 is word bits 8:0 and lane 1 is bits 17:9. `wr_strb_n[0]` low with `wr_strb_n[1]` high stores only lane 0 of that beat. `wr_strb_n[1]` low with `wr_strb_n[0]` high stores only lane 1. The other lane keeps its old value.
- R4: Both strobe bits low on a beat stores all 18 bits of that beat.
- R5: Both strobe bits high on a beat leaves the target word unchanged, whatever is on `wr_data`.
- R6: Strobes are sampled on the same edge as the data beat they qualify, so each of the four beats of a burst may use a different strobe pattern.
- R7: Beat k (k = 0..3) is written to address {`wr_addr`[ADDR_W-1:2], k}, using the address sampled with the request.
- R8: A request may be accepted every second rising edge, so bursts stream back to back. A low `wr_sel_n` on the rising edge right after an accepted request is ignored.
- R9: A synchronous active-low reset discards a burst in progress, so none of its remaining beats are stored. Reset does not clear or alter the array contents.
- R10: Beats 0 and 1 become visible on the read port after rising edge t+2. Beats 2 and 3 become visible after rising edge t+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; both edges sample write data |
| rst_n | input | 1 | Synchronous active-low reset of the burst state |
| wr_sel_n | input | 1 | Active-low write request, sampled on rising edges |
| wr_addr | input | ADDR_W | Write address sampled with the request |
| wr_data | input | 18 | Write data beat, two 9-bit lanes |
| wr_strb_n | input | 2 | Active-low lane strobes for the current beat |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 18 | Array word at `rd_addr`, combinational |

## Verification
In a chained stream, three things fall on the same rising edge. The tail commit of one burst (beats 2 and 3 into the array) coincides with the capture of beat 0 of the next burst. One edge earlier, the next request is accepted while beat 2 of the current burst is captured. The bench provokes this by streaming three bursts with no idle cycle, to different addresses and with different data. It then judges every written word against a bench-side model, so a misplaced base address or a mixed-up capture register shows up as a wrong word. A request poked on the edge right after acceptance is judged the same way: it must leave its own target words untouched.

// File: rtl/qbw_pkg.sv
// Shared constants and types for the burst write port.
// Assumes a word made of two equal byte lanes and a burst length of four.
package qbw_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;
    localparam int BEATS  = 4;
    localparam int PAIRS  = 2;   // beats committed per rising edge

    // One captured beat: data and active-high lane enables.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [LANES-1:0]  wen;
    } beat_t;

    // Rising-edge phase of the request tracker.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/qbw_capture.sv
// Dual-edge beat capture. One register samples the bus on rising edges and
// one samples it on falling edges. The strobes are inverted to active-high
// lane enables. Assumes the data and strobes are stable around both edges.
module qbw_capture
    import qbw_pkg::*;
(
    input  logic              clk,
    input  logic [WORD_W-1:0] bus_data,
    input  logic [LANES-1:0]  bus_strb_n,
    output beat_t             rise_beat,
    output beat_t             fall_beat
);
    logic [LANES-1:0] lane_en;

    // Turn the active-low strobes into active-high lane enables.
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : gen_lane
            assign lane_en[l] = ~bus_strb_n[l];
        end
    endgenerate

    // Capture the beat that sits on the bus at each rising edge.
    always_ff @(posedge clk) begin
        rise_beat <= '{data: bus_data, wen: lane_en};
    end

    // Capture the beat that sits on the bus at each falling edge.
    always_ff @(negedge clk) begin
        fall_beat <= '{data: bus_data, wen: lane_en};
    end
endmodule

// File: rtl/qbw_ctrl.sv
// Request tracker. It accepts a write request on a rising edge and holds the
// burst base address. It raises head_we for the commit of beats 0 and 1 at
// edge t+2 and tail_we for the commit of beats 2 and 3 at edge t+3.
// Assumes a synchronous active-low reset; commits are suppressed while it is
// low.
module qbw_ctrl
    import qbw_pkg::*;
#(
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_n,
    input  logic [BASE_W-1:0] req_base,
    output logic              head_we,
    output logic              tail_we,
    output logic [BASE_W-1:0] head_base,
    output logic [BASE_W-1:0] tail_base
);
    phase_e            phase_q;
    logic [BASE_W-1:0] base_q;
    logic [BASE_W-1:0] tail_base_q;
    logic              tail_pend_q;
    logic              accept;

    // Take a request unless the previous request was taken on the last edge.
    assign accept = (phase_q != PH_FIRST) && !req_n;

    // Advance the phase of the current burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (accept) begin
            phase_q <= PH_FIRST;
        end else if (phase_q == PH_FIRST) begin
            phase_q <= PH_SECOND;
        end else begin
            phase_q <= PH_IDLE;
        end
    end

    // Hold the base address of the burst that was accepted last.
    always_ff @(posedge clk) begin
        if (accept) begin
            base_q <= req_base;
        end
    end

    // Carry the base and a pending flag forward for the tail commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_pend_q <= 1'b0;
        end else begin
            tail_pend_q <= (phase_q == PH_SECOND);
        end
        if (phase_q == PH_SECOND) begin
            tail_base_q <= base_q;
        end
    end

    assign head_we   = (phase_q == PH_SECOND) && rst_n;
    assign tail_we   = tail_pend_q && rst_n;
    assign head_base = base_q;
    assign tail_base = tail_base_q;

    // R8: the edge right after an accepted request never accepts another
    assert_adjacent_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R2: an accepted request leads to the head commit two edges later
    assert_head_after_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 head_we);

    // R7: the tail commit follows the head commit with the same base
    assert_tail_follows_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        head_we |=> (tail_we && tail_base == $past(head_base)));
endmodule

// File: rtl/qbw_array.sv
// Word array with two lane-masked write ports and one combinational read
// port. Assumes the two write ports never target the same word on one edge.
// The contents are not reset.
module qbw_array
    import qbw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                          clk,
    input  logic [PAIRS-1:0][LANES-1:0]   wen,
    input  logic [PAIRS-1:0][ADDR_W-1:0]  waddr,
    input  logic [PAIRS-1:0][WORD_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]             raddr,
    output logic [WORD_W-1:0]             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store each enabled lane of each write port.
    always_ff @(posedge clk) begin
        for (int p = 0; p < PAIRS; p++) begin
            for (int l = 0; l < LANES; l++) begin
                if (wen[p][l]) begin
                    mem[waddr[p]][l*LANE_W +: LANE_W] <= wdata[p][l*LANE_W +: LANE_W];
                end
            end
        end
        // R7: ports writing on the same edge target distinct words
        if (|wen[0] && |wen[1]) begin
            assert_ports_distinct_R7: assert (waddr[0] != waddr[1])
                else $error("two ports wrote the same word");
        end
    end

    // Present the addressed word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/qburst_wr_port.sv
// Top of the burst-of-four double-rate masked write port. Beats taken on
// rising edges feed write port 0 and beats taken on falling edges feed write
// port 1. Head and tail commits pick the base address and the upper beat-index
// bit. Assumes ADDR_W >= 3.
module qburst_wr_port
    import qbw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [17:0]       wr_data,
    input  logic [1:0]        wr_strb_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [17:0]       rd_data
);
    localparam int BASE_W = ADDR_W - $clog2(BEATS);

    beat_t                         rise_beat;
    beat_t                         fall_beat;
    logic                          head_we;
    logic                          tail_we;
    logic [BASE_W-1:0]             head_base;
    logic [BASE_W-1:0]             tail_base;
    logic [BASE_W-1:0]             commit_base;
    logic [PAIRS-1:0][LANES-1:0]   arr_wen;
    logic [PAIRS-1:0][ADDR_W-1:0]  arr_addr;
    logic [PAIRS-1:0][WORD_W-1:0]  arr_data;
    beat_t [PAIRS-1:0]             pair_beat;

    qbw_capture u_capture (
        .clk        (clk),
        .bus_data   (wr_data),
        .bus_strb_n (wr_strb_n),
        .rise_beat  (rise_beat),
        .fall_beat  (fall_beat)
    );

    qbw_ctrl #(.BASE_W(BASE_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (wr_sel_n),
        .req_base  (wr_addr[ADDR_W-1:$clog2(BEATS)]),
        .head_we   (head_we),
        .tail_we   (tail_we),
        .head_base (head_base),
        .tail_base (tail_base)
    );

    // Pick the base of the burst whose pair is being committed.
    assign commit_base = tail_we ? tail_base : head_base;
    assign pair_beat[0] = rise_beat;
    assign pair_beat[1] = fall_beat;

    // Route each captured beat to its write port and word address.
    genvar p;
    generate
        for (p = 0; p < PAIRS; p++) begin : gen_port
            assign arr_addr[p] = {commit_base, tail_we, 1'(p)};
            assign arr_data[p] = pair_beat[p].data;
            assign arr_wen[p]  = pair_beat[p].wen & {LANES{head_we | tail_we}};
        end
    endgenerate

    qbw_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .wen   (arr_wen),
        .waddr (arr_addr),
        .wdata (arr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // R8: head and tail commits never overlap, even when bursts stream
    assert_commit_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(head_we && tail_we));

    // R9: no commit is issued on the edge after reset is applied
    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |-> !(head_we || tail_we));
endmodule

// File: tb/qburst_wr_port_bench.sv
// Directed bench for the burst write port. A bench-side model of the array
// is updated from the requirements and compared through the read port.
module qburst_wr_port_bench;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk;
    logic          rst_n;
    logic          wr_sel_n;
    logic [AW-1:0] wr_addr;
    logic [17:0]   wr_data;
    logic [1:0]    wr_strb_n;
    logic [AW-1:0] rd_addr;
    logic [17:0]   rd_data;

    logic [17:0] exp_mem [DEPTH];
    int checks = 0;
    int errors = 0;

    qburst_wr_port #(.ADDR_W(AW)) u_qburst_wr_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel_n  (wr_sel_n),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_strb_n (wr_strb_n),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [17:0] mk(input int seed, input int i);
        return 18'(seed * 977 + i * 131 + 5);
    endfunction

    // Compare one word against an expected value.
    task automatic check_val(input logic [AW-1:0] a, input logic [17:0] e, input string tag);
        rd_addr = a;
        #1;
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, rd_data, e);
        end
    endtask

    task automatic check_word(input logic [AW-1:0] a, input string tag);
        check_val(a, exp_mem[a], tag);
    endtask

    // Apply a burst to the bench model.
    task automatic model(input logic [AW-1:0] a, input logic [3:0][17:0] d, input logic [3:0][1:0] s);
        for (int i = 0; i < 4; i++) begin
            logic [AW-1:0] w;
            w = {a[AW-1:2], 2'(i)};
            if (!s[i][0]) exp_mem[w][8:0]  = d[i][8:0];
            if (!s[i][1]) exp_mem[w][17:9] = d[i][17:9];
        end
    endtask

    // Issue a request; returns a quarter period after the sampling edge.
    task automatic start(input logic [AW-1:0] a);
        @(negedge clk); #5;
        wr_sel_n = 1'b0;
        wr_addr  = a;
        @(posedge clk); #5;
    endtask

    // Drive four beats. nxt 1 chains a request at t+2; nxt 2 pokes one at t+1.
    task automatic body(input logic [3:0][17:0] d, input logic [3:0][1:0] s,
                        input int nxt, input logic [AW-1:0] na);
        wr_sel_n = 1'b1;
        @(negedge clk); #5;
        wr_data = d[0]; wr_strb_n = s[0];
        if (nxt == 2) begin wr_sel_n = 1'b0; wr_addr = na; end
        @(posedge clk); #5;
        wr_data = d[1]; wr_strb_n = s[1]; wr_sel_n = 1'b1;
        @(negedge clk); #5;
        wr_data = d[2]; wr_strb_n = s[2];
        if (nxt == 1) begin wr_sel_n = 1'b0; wr_addr = na; end
        @(posedge clk); #5;
        wr_data = d[3]; wr_strb_n = s[3];
    endtask

    task automatic settle();
        @(posedge clk); #5;
    endtask

    // R4 R7 R8: fill the whole array with chained full-word bursts.
    task automatic t_fill();
        logic [3:0][17:0] d;
        start('0);
        for (int b = 0; b < DEPTH / 4; b++) begin
            for (int i = 0; i < 4; i++) d[i] = mk(b, i);
            body(d, '0, (b < DEPTH / 4 - 1) ? 1 : 0, AW'((b + 1) * 4));
            model(AW'(b * 4), d, '0);
        end
        settle();
        for (int a = 0; a < DEPTH; a++) check_word(AW'(a), "R4_fill");
    endtask

    // R3 R5 R6: each beat uses a different strobe pattern.
    task automatic t_lanes();
        logic [3:0][17:0] d;
        logic [3:0][1:0]  s;
        for (int i = 0; i < 4; i++) d[i] = mk(100, i) ^ 18'h2AAAA;
        s[0] = 2'b10; s[1] = 2'b01; s[2] = 2'b00; s[3] = 2'b11;
        start(AW'(8));
        body(d, s, 0, '0);
        model(AW'(8), d, s);
        settle();
        check_word(AW'(8),  "R3_lane0_only");
        check_word(AW'(9),  "R3_lane1_only");
        check_word(AW'(10), "R6_full_beat2");
        check_word(AW'(11), "R5_abort_beat3");
    endtask

    // R5: a burst with every beat aborted leaves memory unchanged.
    task automatic t_abort();
        logic [3:0][17:0] d;
        for (int i = 0; i < 4; i++) d[i] = ~mk(7, i);
        start(AW'(16));
        body(d, {4{2'b11}}, 0, '0);
        settle();
        for (int i = 16; i < 20; i++) check_word(AW'(i), "R5_abort_all");
    endtask

    // R2 R10: head pair lands at t+2, tail pair at t+3.
    task automatic t_timing();
        logic [3:0][17:0] d;
        for (int i = 0; i < 4; i++) d[i] = mk(55, i) ^ 18'h15555;
        start(AW'(24));
        body(d, '0, 0, '0);
        check_val(AW'(24), d[0], "R10_head_beat0");
        check_val(AW'(25), d[1], "R10_head_beat1");
        check_word(AW'(26), "R10_tail_not_yet");
        model(AW'(24), d, '0);
        settle();
        check_word(AW'(26), "R2_beat2");
        check_word(AW'(27), "R2_beat3");
    endtask

    // R7: low address bits are ignored for the burst base.
    task automatic t_align();
        logic [3:0][17:0] d;
        for (int i = 0; i < 4; i++) d[i] = mk(300, i);
        start(AW'(31));
        body(d, '0, 0, '0);
        model(AW'(28), d, '0);
        settle();
        for (int i = 28; i < 32; i++) check_word(AW'(i), "R7_aligned");
        check_word(AW'(32), "R7_neighbour");
    endtask

    // R8: three bursts stream back to back with mixed strobes.
    task automatic t_chain();
        logic [3:0][17:0] d;
        logic [3:0][1:0]  s;
        logic [AW-1:0] bases [3];
        bases[0] = AW'(40); bases[1] = AW'(4); bases[2] = AW'(52);
        start(bases[0]);
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 4; i++) begin
                d[i] = mk(500 + b, i);
                s[i] = 2'((b + i) % 3);
            end
            body(d, s, (b < 2) ? 1 : 0, (b < 2) ? bases[b + 1] : '0);
            model(bases[b], d, s);
        end
        settle();
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 4; i++) check_word(bases[b] + AW'(i), "R8_chain");
    endtask

    // R8: a request on the edge right after acceptance is ignored.
    task automatic t_poke();
        logic [3:0][17:0] d;
        for (int i = 0; i < 4; i++) d[i] = mk(777, i);
        start(AW'(44));
        body(d, '0, 2, AW'(60));
        model(AW'(44), d, '0);
        settle(); settle();
        for (int i = 44; i < 48; i++) check_word(AW'(i), "R8_poked_burst");
        for (int i = 60; i < 64; i++) check_word(AW'(i), "R8_poke_ignored");
    endtask

    // R1: beats on the bus without a request store nothing.
    task automatic t_nosel();
        logic [3:0][17:0] d;
        for (int i = 0; i < 4; i++) d[i] = mk(901, i);
        wr_addr = AW'(12);
        body(d, '0, 0, '0);
        settle(); settle();
        for (int i = 12; i < 16; i++) check_word(AW'(i), "R1_no_request");
    endtask

    // R9: reset during a burst discards it and keeps the array contents.
    task automatic t_reset();
        logic [3:0][17:0] d;
        for (int i = 0; i < 4; i++) d[i] = mk(1234, i);
        start(AW'(36));
        rst_n = 1'b0;
        body(d, '0, 0, '0);
        rst_n = 1'b1;
        settle(); settle();
        for (int i = 36; i < 40; i++) check_word(AW'(i), "R9_burst_dropped");
        check_word(AW'(0), "R9_contents_kept");
    endtask

    initial begin
        rst_n     = 1'b0;
        wr_sel_n  = 1'b1;
        wr_addr   = '0;
        wr_data   = '0;
        wr_strb_n = 2'b11;
        rd_addr   = '0;
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        t_fill();
        t_nosel();
        t_lanes();
        t_abort();
        t_timing();
        t_align();
        t_chain();
        t_poke();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule